// File: doc/BRIEF.md
# Octal Switch Serial Command and Status Shifter

This block is the serial front end of an eight-channel output switch controller. A host talks to it over a SPI slave port (mode 0, MSB first) in fixed 16-bit frames. In each frame the block first shifts out a snapshot of the eight per-channel fault flags. It then shifts back the first byte it received in that same frame, so the host can compare what it sent with what it read and confirm that the link is intact. The second byte received is the new switch command. It is applied to the command vector only when chip select returns high after exactly sixteen clock pulses.

The SPI pins are brought into the core clock domain through a synchronizer, and edges are detected there. The whole block therefore runs on one system clock with a synchronous active-low reset. The serial clock must be slow enough that each of its phases spans several system clocks. The fault vector comes from a separate fault block, and the command vector is handed back to that block and to the output drivers.

Top module: `octal_spi_front`

## Requirements
- R1: While reset is held, and after its release until the first valid frame, `cmd_vec` is all zeros and `spi_miso` is 0.
- R2: The first eight bits on `spi_miso` in a frame are `fault_vec[7]` down to `fault_vec[0]`, MSB first. The first bit is valid before the first rising edge of `spi_sck`. A 1 means the channel is faulted and a 0 means it is healthy.
- R3: Bits nine to sixteen on `spi_miso` repeat the first byte received on `spi_mosi` in that frame, MSB first.
- R4: Data on `spi_mosi` is sampled on rising `spi_sck`, MSB first. After a 16-bit frame, the second received byte appears on `cmd_vec` once `spi_cs_n` rises. Bit i of that byte drives channel i, with 1 meaning on and 0 meaning off.
- R5: A frame that ends with any rising-clock count other than 16 (fewer or more) leaves `cmd_vec` unchanged.
- R6: The fault vector is captured when chip select falls. Changes on `fault_vec` later in the frame do not alter the bits shifted out in that frame.
- R7: `spi_miso` is driven to 0 while `spi_cs_n` is high.
- R8: `cmd_vec` does not change while a frame is in progress, including after its sixteenth bit and before chip select rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_sck | input | 1 | Serial clock, idle low |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial data to host, 0 when deselected |
| fault_vec | input | 8 | Per-channel fault flags from the fault block |
| cmd_vec | output | 8 | Per-channel on/off command |

## Verification
Two events can land in one system clock. The first is the commit of a finished frame on the rising edge of chip select. The second is a change of the fault vector that the next frame must report. The bench provokes this by changing `fault_vec` in the same cycle that it raises chip select. It then checks that `cmd_vec` holds the old frame's command byte and that the following frame reports the new fault value. A sweep over all 256 fault patterns, each paired with computed loopback and command bytes, judges both effects every time.

// File: rtl/spi_sw_pkg.sv
// Package: shared defaults and frame-length helper for the octal switch
// serial front end. Assumes two bytes per frame (status/echo + command).
package spi_sw_pkg;
    localparam int DEF_CHANNELS    = 8;
    localparam int DEF_SYNC_STAGES = 2;

    // Frame length in bits for a given channel count.
    function automatic int frame_len(input int channels);
        return 2 * channels;
    endfunction
endpackage

// File: rtl/spi_in_sync.sv
// Module: multi-bit level synchronizer for asynchronous SPI pins.
// Assumes each bit toggles slowly relative to clk (no bus coherency needed).
module spi_in_sync #(
    parameter int          WIDTH   = 3,
    parameter int          STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [STAGES-1:0][WIDTH-1:0] pipe;

    // Purpose: shift asynchronous pins through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) pipe[i] <= RST_VAL;
        end else begin
            pipe[0] <= din;
            for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
        end
    end

    assign dout = pipe[STAGES-1];
endmodule

// File: rtl/frame_shifter.sv
// Module: detects chip-select and serial-clock edges and runs one byte-wide
// shift register. It loads the fault snapshot on select fall, shifts in on
// clock rise (so its content becomes the echo byte after eight bits and the
// command byte after sixteen), and updates data out on clock fall.
// Assumes synchronized inputs and mode 0 (clock low when select falls).
module frame_shifter #(
    parameter int CH  = 8,
    parameter int CW  = 5,
    parameter int SAT = 17
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_s,
    input  logic          sck_s,
    input  logic          mosi_s,
    input  logic [CH-1:0] status,
    output logic          miso_q,
    output logic [CH-1:0] rx_byte,
    output logic [CW-1:0] bit_cnt,
    output logic          frame_end
);
    logic          cs_d, sck_d;
    logic          cs_fall, sck_rise, sck_fall;
    logic [CH-1:0] sr;

    assign cs_fall   = cs_d & ~cs_s;
    assign frame_end = ~cs_d & cs_s;
    assign sck_rise  = ~sck_d & sck_s;
    assign sck_fall  = sck_d & ~sck_s;

    // Purpose: edge history, status load, shift-in, bit count and data-out update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_d    <= 1'b1;
            sck_d   <= 1'b0;
            sr      <= '0;
            bit_cnt <= '0;
            miso_q  <= 1'b0;
        end else begin
            cs_d  <= cs_s;
            sck_d <= sck_s;
            if (cs_fall) begin
                sr      <= status;
                bit_cnt <= '0;
                miso_q  <= status[CH-1];
            end else if (!cs_s) begin
                if (sck_rise) begin
                    sr <= {sr[CH-2:0], mosi_s};
                    if (bit_cnt != CW'(SAT)) bit_cnt <= bit_cnt + 1'b1;
                end
                if (sck_fall) miso_q <= sr[CH-1];
            end
        end
    end

    assign rx_byte = sr;

    // R2: first data-out bit after select fall is the captured status MSB.
    p_load_msb_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cs_fall |=> (miso_q == $past(status[CH-1])));

    // R3/R4: a rising serial clock inside a frame shifts the data-in bit in at the LSB.
    p_shift_in_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_s && sck_rise && !cs_fall) |=> (sr[0] == $past(mosi_s)));

    // R5: the bit counter saturates and never runs past its limit.
    p_cnt_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_cnt == CW'(SAT)) |=> (bit_cnt == CW'(SAT) || $past(cs_fall)));
endmodule

// File: rtl/cmd_latch.sv
// Module: output command register. Copies the received byte on the end of a
// frame whose bit count is exactly the frame length; otherwise holds.
module cmd_latch #(
    parameter int CH    = 8,
    parameter int CW    = 5,
    parameter int FRAME = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          frame_end,
    input  logic [CW-1:0] bit_cnt,
    input  logic [CH-1:0] rx_byte,
    output logic [CH-1:0] cmd_q
);
    logic commit;
    assign commit = frame_end && (bit_cnt == CW'(FRAME));

    // Purpose: clear on reset, load command byte on a well-formed frame end.
    always_ff @(posedge clk) begin
        if (!rst_n)      cmd_q <= '0;
        else if (commit) cmd_q <= rx_byte;
    end

    // R1: reset clears the command vector.
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (cmd_q == '0));

    // R8: no frame end, no command change.
    p_hold_midframe_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_end |=> $stable(cmd_q));

    // R5: a frame with the wrong bit count is discarded.
    p_discard_bad_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_end && bit_cnt != CW'(FRAME)) |=> $stable(cmd_q));

    // R4: a good frame end applies the received byte.
    p_commit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_end && bit_cnt == CW'(FRAME)) |=> (cmd_q == $past(rx_byte)));
endmodule

// File: rtl/octal_spi_front.sv
// Module: top of the SPI command/status front end. Synchronizes the pins,
// runs the frame shifter and the command register, and forces data out
// low while deselected. Assumes the serial clock phase spans at least
// SYNC_STAGES+2 system clocks.
module octal_spi_front
    import spi_sw_pkg::*;
#(
    parameter int CHANNELS    = DEF_CHANNELS,
    parameter int SYNC_STAGES = DEF_SYNC_STAGES
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                spi_cs_n,
    input  logic                spi_sck,
    input  logic                spi_mosi,
    output logic                spi_miso,
    input  logic [CHANNELS-1:0] fault_vec,
    output logic [CHANNELS-1:0] cmd_vec
);
    localparam int FRAME = frame_len(CHANNELS);
    localparam int SAT   = FRAME + 1;
    localparam int CW    = $clog2(FRAME + 2);

    logic [2:0]          pins_s;
    logic                miso_q, frame_end;
    logic [CHANNELS-1:0] rx_byte;
    logic [CW-1:0]       bit_cnt;

    spi_in_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .din({spi_cs_n, spi_sck, spi_mosi}),
        .dout(pins_s)
    );

    frame_shifter #(.CH(CHANNELS), .CW(CW), .SAT(SAT)) u_shift (
        .clk(clk), .rst_n(rst_n),
        .cs_s(pins_s[2]), .sck_s(pins_s[1]), .mosi_s(pins_s[0]),
        .status(fault_vec),
        .miso_q(miso_q), .rx_byte(rx_byte),
        .bit_cnt(bit_cnt), .frame_end(frame_end)
    );

    cmd_latch #(.CH(CHANNELS), .CW(CW), .FRAME(FRAME)) u_cmd (
        .clk(clk), .rst_n(rst_n),
        .frame_end(frame_end), .bit_cnt(bit_cnt), .rx_byte(rx_byte),
        .cmd_q(cmd_vec)
    );

    assign spi_miso = pins_s[2] ? 1'b0 : miso_q;
endmodule

// File: tb/tb_octal_spi_front.sv
module tb_octal_spi_front;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       spi_cs_n = 1'b1, spi_sck = 1'b0, spi_mosi = 1'b0;
    logic       spi_miso;
    logic [7:0] fault_vec = 8'h00;
    logic [7:0] cmd_vec;

    int  checks = 0, failures = 0;
    bit  done = 1'b0;
    logic [7:0] cmd_model = 8'h00;

    octal_spi_front dut (
        .clk(clk), .rst_n(rst_n), .spi_cs_n(spi_cs_n), .spi_sck(spi_sck),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso),
        .fault_vec(fault_vec), .cmd_vec(cmd_vec)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // One frame of nbits; status before select fall, mid_status after; end_status at select rise.
    task automatic frame(input int nbits, input logic [31:0] tx,
                         input logic [7:0] st, input logic [7:0] mid_st,
                         input logic [7:0] end_st, output logic [31:0] rx);
        rx = '0;
        fault_vec = st;
        wclk(1);
        spi_cs_n = 1'b0;
        wclk(HALF + 2);
        fault_vec = mid_st;
        for (int b = nbits - 1; b >= 0; b--) begin
            spi_mosi = tx[b];
            wclk(HALF);
            rx = {rx[30:0], spi_miso};
            spi_sck = 1'b1;
            wclk(HALF);
            spi_sck = 1'b0;
        end
        wclk(HALF);
        // R8: nothing applied before select rises
        chk("R8 cmd held before cs rise", {24'h0, cmd_vec}, {24'h0, cmd_model});
        spi_cs_n = 1'b1;
        fault_vec = end_st;
        wclk(HALF + 2);
    endtask

    initial begin
        logic [31:0] rx;
        logic [7:0]  b1, b2;
        wclk(3);
        // R1: reset state
        chk("R1 cmd at reset", {24'h0, cmd_vec}, 32'h0);
        chk("R1 miso at reset", {31'h0, spi_miso}, 32'h0);
        rst_n = 1'b1;
        wclk(4);
        chk("R1 cmd after release", {24'h0, cmd_vec}, 32'h0);

        // Sweep all status patterns: R2, R3, R4, R7; status changes at cs rise.
        for (int i = 0; i < 256; i++) begin
            b1 = 8'((i * 73 + 5) & 255);
            b2 = 8'(i * 29) ^ 8'h5A;
            frame(16, {16'h0, b1, b2}, 8'(i), 8'(i), 8'(i + 1), rx);
            cmd_model = b2;
            chk("R2 status bits", {24'h0, rx[15:8]}, 32'(i));
            chk("R3 echo byte", {24'h0, rx[7:0]}, {24'h0, b1});
            chk("R4 command applied", {24'h0, cmd_vec}, {24'h0, b2});
            chk("R7 miso idle low", {31'h0, spi_miso}, 32'h0);
        end

        // R6: status change after select fall is not reported
        frame(16, 32'h0000_C33C, 8'hA5, 8'h5A, 8'h00, rx);
        cmd_model = 8'h3C;
        chk("R6 snapshot status", {24'h0, rx[15:8]}, 32'hA5);
        chk("R4 command 3C", {24'h0, cmd_vec}, 32'h3C);

        // R5: short and long frames are discarded
        frame(8, 32'h0000_00FF, 8'h00, 8'h00, 8'h00, rx);
        chk("R5 8-bit frame discarded", {24'h0, cmd_vec}, {24'h0, cmd_model});
        frame(15, 32'h0000_7FFF, 8'h00, 8'h00, 8'h00, rx);
        chk("R5 15-bit frame discarded", {24'h0, cmd_vec}, {24'h0, cmd_model});
        frame(17, 32'h0001_FFFF, 8'h00, 8'h00, 8'h00, rx);
        chk("R5 17-bit frame discarded", {24'h0, cmd_vec}, {24'h0, cmd_model});
        frame(0, 32'h0, 8'h00, 8'h00, 8'h00, rx);
        chk("R5 empty frame discarded", {24'h0, cmd_vec}, {24'h0, cmd_model});

        // R4: good frame still works afterwards, all-zero command
        frame(16, 32'h0000_FF00, 8'hFF, 8'hFF, 8'hFF, rx);
        cmd_model = 8'h00;
        chk("R4 command 00", {24'h0, cmd_vec}, 32'h0);
        chk("R3 echo FF", {24'h0, rx[7:0]}, 32'hFF);

        // R1: reset clears command mid-life
        frame(16, 32'h0000_0081, 8'h00, 8'h00, 8'h00, rx);
        chk("R4 command 81", {24'h0, cmd_vec}, 32'h81);
        rst_n = 1'b0;
        wclk(2);
        chk("R1 cmd cleared by reset", {24'h0, cmd_vec}, 32'h0);
        rst_n = 1'b1;
        wclk(2);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule